// File: doc/BRIEF.md
# Disk DMA Address, Count and Fault Reporting Registers

This block holds the state that a disk DMA engine works from: a word address into mapped memory, a word count, a transfer direction and an enable. The CPU loads the count, direction and enable with one data write. The address is not taken from the data bus. It is loaded from the CPU address lines of a write to the address register, one half per write, and address line 14 selects which half. As the engine finishes each word, the block advances the address by one word and lowers the count. It flags completion when the count reaches zero.

Before each DMA word the engine asks the block to check the access against the page-map bits for the current page. A failed check returns a fault code that tells the direction apart from the fault kind. The block writes a general status word and two bus status words. It can also raise a level-7 interrupt request that stays up until the status is cleared. The data movement itself is handled elsewhere.

Top module: `dma_regfile`

## Requirements
- R1: A count write stores data bits 13:0 plus one as the count, wrapping at 14 bits. It stores data bit 14 as the direction, where 1 means the DMA reads memory. It stores data bit 15 as the enable.
- R2: `cnt_rdata` returns the 14-bit count in bits 13:0, with bits 15:14 always read as 1.
- R3: An address write with line 14 high loads DMA address bits 21:9 from CPU address lines 13:1 and keeps bits 8:1.
- R4: An address write with line 14 low loads DMA address bits 8:1 from CPU address lines 8:1 and keeps bits 21:9.
- R5: While enabled, each `word_done` advances the address by 2, wrapping within 22 bits. It lowers a nonzero count by one, and a zero count stays at zero. While disabled, `word_done` changes neither value. Address bit 0 always reads 0.
- R6: `dma_done` is high exactly when the enable is set and the count is zero.
- R7: Fault kinds are checked in order. Map bits 1:0 equal to 0 give a page fault, with status 0xABFF. In user mode, DMA address bits 21:19 all zero give a protection fault, with status 0xBBFF. Also in user mode, a memory write (direction 0) to a page whose map bit 2 is 0 gives a protection fault, with status 0xBBFF. A direction of 1 ORs in 0x4000, and `pie` ORs in 0x0400.
- R8: On a fault, `bstat0` becomes 0x3C00 OR DMA address bits 21:16, and `bstat1` becomes DMA address bits 15:0.
- R9: A fault sets `irq7` only when `ee` is high. Once set, `irq7` stays high until a clear.
- R10: After reset, and after a `stat_clr` cycle with no fault, all three status words are 0xFFFF and `irq7` is low. A fault in the same cycle as a clear takes precedence over the clear.
- R11: `acc_ok` is high in the same cycle as `acc_req` when no fault applies. A passing check leaves the status words unchanged.
- R12: A count write in the same cycle as `word_done` takes the written value, and an address write takes precedence over the address step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count write data: enable, direction, count |
| addr_wr | input | 1 | Address register write strobe |
| cpu_a | input | 14 | CPU address lines 14:1 of the address write |
| word_done | input | 1 | One DMA word transfer completed |
| acc_req | input | 1 | Check the current DMA address this cycle |
| map_bits | input | 3 | Page-map bits: 2 write enable, 1:0 page state |
| user_mode | input | 1 | DMA check runs with user privileges |
| pie | input | 1 | Parity interrupt enable, reflected in status |
| ee | input | 1 | Error enable for the level-7 request |
| stat_clr | input | 1 | Clear status words and interrupt request |
| dma_addr | output | 22 | Current DMA byte address |
| cnt_rdata | output | 16 | Count readback with top bits set |
| dma_dir | output | 1 | Direction, 1 = DMA reads memory |
| dma_en | output | 1 | DMA enable |
| dma_done | output | 1 | Enabled and count is zero |
| acc_ok | output | 1 | Current access check passes |
| gstat | output | 16 | General status word |
| bstat0 | output | 16 | First bus status word |
| bstat1 | output | 16 | Second bus status word |
| irq7 | output | 1 | Level-7 interrupt request |

## Verification
Every register result, including count, direction, enable, address, the status words and `irq7`, appears one cycle after the clock edge that samples its strobe. `dma_done` follows the count and enable with no further delay. `acc_ok` is combinational, so it is valid in the same cycle as `acc_req`. The bench drives inputs just after a rising edge, so its behavioural model updates on the edge where the design samples them. At each falling edge it compares every output against that model, and the directed checks sample just after the edge that follows each stimulus.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_PAGE    = 2'd1,
      FLT_USER_IO = 2'd2,
      FLT_PROT    = 2'd3
   } flt_kind_t;

   localparam logic [15:0] BUS_TAG   = 16'h3C00;
   localparam logic [15:0] STAT_IDLE = 16'hFFFF;

   function automatic logic [15:0] flt_code(flt_kind_t k, logic rd, logic pie);
      logic [15:0] base;
      case (k)
         FLT_PAGE:    base = 16'hABFF;
         FLT_USER_IO: base = 16'hBAFF;
         FLT_PROT:    base = 16'hBBFF;
         default:     base = STAT_IDLE;
      endcase
      return base | (rd ? 16'h4000 : 16'h0000) | (pie ? 16'h0400 : 16'h0000);
   endfunction

endpackage

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
   parameter int CNT_W = 14,
   parameter int RD_W  = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [RD_W-1:0] wdata,
   input  logic            step,
   output logic            dir,
   output logic            en,
   output logic            done,
   output logic [RD_W-1:0] rdata
);
   localparam int DIR_BIT = RD_W - 2;
   localparam int EN_BIT  = RD_W - 1;

   generate
      if (CNT_W != DIR_BIT) begin : g_bad_cnt_w
         $error("dma_count_reg: count must fill the bits below direction");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir   <= 1'b0;
         en    <= 1'b0;
      end else if (wr) begin
         cnt_q <= wdata[CNT_W-1:0] + CNT_W'(1);
         dir   <= wdata[DIR_BIT];
         en    <= wdata[EN_BIT];
      end else if (step && en && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done = en && (cnt_q == '0);

   generate
      for (genvar i = 0; i < RD_W; i++) begin : g_rd
         if (i < CNT_W) begin : g_cnt
            assign rdata[i] = cnt_q[i];
         end else begin : g_pad
            assign rdata[i] = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
   parameter int ADDR_W  = 22,
   parameter int SPLIT   = 9,
   parameter int SEL_BIT = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [SEL_BIT:1]   a,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr
);
   localparam int HI_W = ADDR_W - SPLIT;
   localparam int WD_W = ADDR_W - 1;

   generate
      if (HI_W >= SEL_BIT) begin : g_bad_hi
         $error("dma_addr_reg: upper half overlaps the select line");
      end
      if (SPLIT < 2 || SPLIT - 1 >= SEL_BIT) begin : g_bad_split
         $error("dma_addr_reg: split point out of range");
      end
   endgenerate

   logic [WD_W-1:0] wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q <= '0;
      end else if (wr && a[SEL_BIT]) begin
         wd_q[WD_W-1:SPLIT-1] <= a[HI_W:1];
      end else if (wr) begin
         wd_q[SPLIT-2:0] <= a[SPLIT-1:1];
      end else if (step) begin
         wd_q <= wd_q + WD_W'(1);
      end
   end

   assign addr = {wd_q, 1'b0};

endmodule

// File: rtl/dma_perm_check.sv
module dma_perm_check
   import dma_regs_pkg::*;
#(
   parameter int REG_W = 3
) (
   input  logic             req,
   input  logic [REG_W-1:0] region,
   input  logic [2:0]       map_bits,
   input  logic             user_mode,
   input  logic             mem_wr,
   output flt_kind_t        kind,
   output logic             ok
);
   logic absent, kern_hit, wp_hit;

   assign absent   = (map_bits[1:0] == 2'b00);
   assign kern_hit = user_mode && (region == '0);
   assign wp_hit   = user_mode && mem_wr && !map_bits[2];

   always_comb begin
      if (!req)          kind = FLT_NONE;
      else if (absent)   kind = FLT_PAGE;
      else if (kern_hit) kind = FLT_PROT;
      else if (wp_hit)   kind = FLT_PROT;
      else               kind = FLT_NONE;
   end

   assign ok = req && (kind == FLT_NONE);

endmodule

// File: rtl/dma_fault_log.sv
module dma_fault_log
   import dma_regs_pkg::*;
#(
   parameter int ADDR_W  = 22,
   parameter int FULL_AW = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  flt_kind_t         kind,
   input  logic              rd,
   input  logic              pie,
   input  logic              ee,
   input  logic [ADDR_W-1:0] addr,
   output logic [15:0]       gstat,
   output logic [15:0]       bstat0,
   output logic [15:0]       bstat1,
   output logic              irq
);
   logic [FULL_AW-1:0] ext;

   generate
      if (FULL_AW != 24) begin : g_bad_full
         $error("dma_fault_log: bus status layout needs a 24-bit address");
      end
      if (ADDR_W < FULL_AW) begin : g_pad
         assign ext = {{(FULL_AW - ADDR_W){1'b0}}, addr};
      end else begin : g_full
         assign ext = addr[FULL_AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gstat  <= STAT_IDLE;
         bstat0 <= STAT_IDLE;
         bstat1 <= STAT_IDLE;
         irq    <= 1'b0;
      end else if (kind != FLT_NONE) begin
         gstat  <= flt_code(kind, rd, pie);
         bstat0 <= BUS_TAG | {8'h00, ext[FULL_AW-1:16]};
         bstat1 <= ext[15:0];
         irq    <= ee | (irq & ~clr);
      end else if (clr) begin
         gstat  <= STAT_IDLE;
         bstat0 <= STAT_IDLE;
         bstat1 <= STAT_IDLE;
         irq    <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
   import dma_regs_pkg::*;
#(
   parameter int CNT_W    = 14,
   parameter int RD_W     = 16,
   parameter int ADDR_W   = 22,
   parameter int SPLIT    = 9,
   parameter int SEL_BIT  = 14,
   parameter int KERN_LSB = 19,
   parameter int FULL_AW  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_wr,
   input  logic [RD_W-1:0]   cnt_wdata,
   input  logic              addr_wr,
   input  logic [SEL_BIT:1]  cpu_a,
   input  logic              word_done,
   input  logic              acc_req,
   input  logic [2:0]        map_bits,
   input  logic              user_mode,
   input  logic              pie,
   input  logic              ee,
   input  logic              stat_clr,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [RD_W-1:0]   cnt_rdata,
   output logic              dma_dir,
   output logic              dma_en,
   output logic              dma_done,
   output logic              acc_ok,
   output logic [15:0]       gstat,
   output logic [15:0]       bstat0,
   output logic [15:0]       bstat1,
   output logic              irq7
);
   localparam int REG_W = ADDR_W - KERN_LSB;

   generate
      if (KERN_LSB >= ADDR_W || KERN_LSB < 1) begin : g_bad_kern
         $error("dma_regfile: kernel region field out of range");
      end
   endgenerate

   flt_kind_t kind;
   logic      addr_step;

   assign addr_step = word_done && dma_en;

   dma_count_reg #(.CNT_W(CNT_W), .RD_W(RD_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cnt_wr),
      .wdata (cnt_wdata),
      .step  (word_done),
      .dir   (dma_dir),
      .en    (dma_en),
      .done  (dma_done),
      .rdata (cnt_rdata)
   );

   dma_addr_reg #(.ADDR_W(ADDR_W), .SPLIT(SPLIT), .SEL_BIT(SEL_BIT)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (addr_wr),
      .a     (cpu_a),
      .step  (addr_step),
      .addr  (dma_addr)
   );

   dma_perm_check #(.REG_W(REG_W)) u_perm (
      .req       (acc_req),
      .region    (dma_addr[ADDR_W-1:KERN_LSB]),
      .map_bits  (map_bits),
      .user_mode (user_mode),
      .mem_wr    (!dma_dir),
      .kind      (kind),
      .ok        (acc_ok)
   );

   dma_fault_log #(.ADDR_W(ADDR_W), .FULL_AW(FULL_AW)) u_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (stat_clr),
      .kind   (kind),
      .rd     (dma_dir),
      .pie    (pie),
      .ee     (ee),
      .addr   (dma_addr),
      .gstat  (gstat),
      .bstat0 (bstat0),
      .bstat1 (bstat1),
      .irq    (irq7)
   );

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
   parameter int CNT_W  = 14,
   parameter int ADDR_W = 22,
   parameter int SPLIT  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_wr,
   input logic              wd_dir,
   input logic              wd_en,
   input logic              addr_wr,
   input logic              a_sel,
   input logic              word_done,
   input logic              acc_req,
   input logic              acc_ok,
   input logic              ee,
   input logic              stat_clr,
   input logic [CNT_W-1:0]  cnt_low,
   input logic [ADDR_W-1:0] dma_addr,
   input logic              dma_dir,
   input logic              dma_en,
   input logic              dma_done,
   input logic [15:0]       gstat,
   input logic [15:0]       bstat1,
   input logic              irq7
);

   assert_flags_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (dma_dir == $past(wd_dir)) && (dma_en == $past(wd_en)));

   assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_wr && !a_sel) |=> dma_addr[ADDR_W-1:SPLIT] == $past(dma_addr[ADDR_W-1:SPLIT]));

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && dma_en && !addr_wr) |=> dma_addr == ADDR_W'($past(dma_addr) + ADDR_W'(2)));

   assert_done_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |-> (cnt_low == '0) && dma_en);

   assert_bus_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_ok) |=> bstat1 == $past(dma_addr[15:0]));

   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq7) |-> $past(ee));

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !acc_req) |=> (gstat == 16'hFFFF) && !irq7);

   assert_ok_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |-> acc_req);

endmodule

bind dma_regfile dma_regfile_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_wr    (cnt_wr),
   .wd_dir    (cnt_wdata[RD_W-2]),
   .wd_en     (cnt_wdata[RD_W-1]),
   .addr_wr   (addr_wr),
   .a_sel     (cpu_a[SEL_BIT]),
   .word_done (word_done),
   .acc_req   (acc_req),
   .acc_ok    (acc_ok),
   .ee        (ee),
   .stat_clr  (stat_clr),
   .cnt_low   (cnt_rdata[CNT_W-1:0]),
   .dma_addr  (dma_addr),
   .dma_dir   (dma_dir),
   .dma_en    (dma_en),
   .dma_done  (dma_done),
   .gstat     (gstat),
   .bstat1    (bstat1),
   .irq7      (irq7)
);

// File: tb/dma_regfile_tb.sv
`timescale 1ns/1ps
module dma_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        addr_wr = 1'b0;
   logic [14:1] cpu_a = '0;
   logic        word_done = 1'b0;
   logic        acc_req = 1'b0;
   logic [2:0]  map_bits = 3'b111;
   logic        user_mode = 1'b0;
   logic        pie = 1'b0;
   logic        ee = 1'b0;
   logic        stat_clr = 1'b0;
   logic [21:0] dma_addr;
   logic [15:0] cnt_rdata, gstat, bstat0, bstat1;
   logic        dma_dir, dma_en, dma_done, acc_ok, irq7;

   int nchk = 0, nfail = 0, cycles = 0;
   bit running = 0;

   int m_cnt, m_dir, m_en, m_addr, m_gs, m_b0, m_b1, m_irq;

   always #2.5 clk = ~clk;

   dma_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .addr_wr(addr_wr), .cpu_a(cpu_a), .word_done(word_done), .acc_req(acc_req),
      .map_bits(map_bits), .user_mode(user_mode), .pie(pie), .ee(ee),
      .stat_clr(stat_clr), .dma_addr(dma_addr), .cnt_rdata(cnt_rdata),
      .dma_dir(dma_dir), .dma_en(dma_en), .dma_done(dma_done), .acc_ok(acc_ok),
      .gstat(gstat), .bstat0(bstat0), .bstat1(bstat1), .irq7(irq7)
   );

   // fault kind from requirement R7: 0 none, 1 page, 3 protection
   function automatic int fkind();
      if (!acc_req) return 0;
      if (map_bits[1:0] == 2'b00) return 1;
      if (user_mode && ((m_addr >> 19) & 7) == 0) return 3;
      if (user_mode && m_dir == 0 && !map_bits[2]) return 3;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_dir = 0; m_en = 0; m_addr = 0;
         m_gs = 'hFFFF; m_b0 = 'hFFFF; m_b1 = 'hFFFF; m_irq = 0;
      end else begin
         int k;
         k = fkind();
         if (k != 0) begin
            m_gs = ((k == 1) ? 'hABFF : 'hBBFF) | (m_dir ? 'h4000 : 0) | (pie ? 'h0400 : 0);
            m_b0 = 'h3C00 | (m_addr >> 16);
            m_b1 = m_addr & 'hFFFF;
            m_irq = ee ? 1 : (stat_clr ? 0 : m_irq);
         end else if (stat_clr) begin
            m_gs = 'hFFFF; m_b0 = 'hFFFF; m_b1 = 'hFFFF; m_irq = 0;
         end
         if (addr_wr && cpu_a[14])
            m_addr = (m_addr & 'h1FE) | ((int'(cpu_a) << 1 & 'h3FFE) << 8);
         else if (addr_wr)
            m_addr = (m_addr & 'h3FFE00) | ((int'(cpu_a) << 1) & 'h1FE);
         else if (word_done && m_en)
            m_addr = (m_addr + 2) & 'h3FFFFE;
         if (cnt_wr) begin
            m_cnt = ((cnt_wdata & 'h3FFF) + 1) & 'h3FFF;
            m_dir = cnt_wdata[14];
            m_en  = cnt_wdata[15];
         end else if (word_done && m_en && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running && rst_n) begin
         chk("R1 R12 direction", dma_dir, m_dir);
         chk("R1 enable", dma_en, m_en);
         chk("R2 count readback", cnt_rdata, m_cnt | 'hC000);
         chk("R3 R4 R5 R12 address", dma_addr, m_addr);
         chk("R6 done", dma_done, (m_en && m_cnt == 0) ? 1 : 0);
         chk("R11 access ok", acc_ok, (acc_req && fkind() == 0) ? 1 : 0);
         chk("R7 R10 general status", gstat, m_gs);
         chk("R8 bus status 0", bstat0, m_b0);
         chk("R8 bus status 1", bstat1, m_b1);
         chk("R9 irq", irq7, m_irq);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         nfail++; nchk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask
   task automatic wr_cnt(input logic [15:0] d);
      cnt_wr = 1; cnt_wdata = d; cyc(); cnt_wr = 0;
   endtask
   task automatic wr_addr(input logic [14:1] a);
      addr_wr = 1; cpu_a = a; cyc(); addr_wr = 0;
   endtask
   task automatic words(input int n);
      for (int i = 0; i < n; i++) begin word_done = 1; cyc(); end
      word_done = 0;
   endtask
   task automatic access(input logic [2:0] mb, input logic um);
      map_bits = mb; user_mode = um; acc_req = 1; #1;
      chk("R11 same-cycle ok", acc_ok, (mb[1:0] != 0 && !(um && ((m_addr >> 19) & 7) == 0)
                                       && !(um && m_dir == 0 && !mb[2])) ? 1 : 0);
      cyc(); acc_req = 0; map_bits = 3'b111; user_mode = 0;
   endtask
   task automatic clear();
      stat_clr = 1; cyc(); stat_clr = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1; running = 1;
      cyc();
      // reset state, R10
      chk("R10 reset status", gstat, 'hFFFF);
      chk("R2 reset readback", cnt_rdata, 'hC000);

      wr_cnt(16'h8005);
      chk("R1 count plus one", cnt_rdata, 'hC006);
      chk("R1 enable set", dma_en, 1);
      wr_addr({1'b1, 13'h1ABC});
      chk("R3 upper half", dma_addr, 'h357800);
      wr_addr({1'b0, 5'h1F, 8'h5A});
      chk("R4 lower half", dma_addr, 'h3578B4);
      words(3);
      chk("R5 step address", dma_addr, 'h3578BA);
      chk("R5 step count", cnt_rdata, 'hC003);
      words(3);
      chk("R6 done at zero", dma_done, 1);
      words(1);
      chk("R5 count holds zero", cnt_rdata, 'hC000);

      wr_cnt(16'h0004);
      words(2);
      chk("R5 disabled ignores words", cnt_rdata, 'hC005);
      chk("R5 disabled keeps address", dma_addr, 'h3578C2);

      cnt_wr = 1; cnt_wdata = 16'h8010; word_done = 1; cyc();
      cnt_wr = 0; word_done = 0;
      chk("R12 write beats step", cnt_rdata, 'hC011);
      addr_wr = 1; cpu_a = {1'b0, 5'h00, 8'h01}; word_done = 1; cyc();
      addr_wr = 0; word_done = 0;
      chk("R12 address write beats step", dma_addr, 'h357802);

      access(3'b000, 0);
      chk("R7 page fault code", gstat, 'hABFF);
      chk("R8 bus tag", bstat0, 'h3C35);
      chk("R9 no irq without ee", irq7, 0);
      clear();
      access(3'b111, 0);
      chk("R11 pass leaves status", gstat, 'hFFFF);

      wr_cnt(16'h4008); ee = 1; pie = 1;
      access(3'b100, 0);
      chk("R7 read page fault code", gstat, 'hEFFF);
      chk("R9 irq raised", irq7, 1);
      cyc();
      chk("R9 irq held", irq7, 1);

      wr_cnt(16'h8008);
      stat_clr = 1; access(3'b011, 1); stat_clr = 0;
      chk("R10 fault beats clear", gstat, 'hBFFF);
      clear();
      chk("R10 clear", gstat, 'hFFFF);
      chk("R10 clear irq", irq7, 0);

      ee = 0; pie = 0;
      wr_addr({1'b1, 13'h0001});
      access(3'b111, 1);
      chk("R7 kernel fault", gstat, 'hBBFF);
      chk("R9 stays low", irq7, 0);
      access(3'b011, 0);
      clear();

      wr_addr({1'b1, 13'h1FFF});
      wr_addr({1'b0, 5'h00, 8'hFF});
      chk("R3 R4 top address", dma_addr, 'h3FFFFE);
      words(1);
      chk("R5 address wrap", dma_addr, 0);
      wr_cnt(16'hBFFF);
      chk("R1 count wrap", cnt_rdata, 'hC000);
      chk("R6 done on wrap", dma_done, 1);
      repeat (4) cyc();

      running = 0;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule